// File: doc/BRIEF.md
# Systolic Pattern Match Counter

This block slides a recirculating pattern past an unbounded text stream. For every text character it reports how many positions of the substring that ends at that character agree with the pattern. It does not return a single all-or-nothing match bit. A pattern entry can be marked as a wildcard, and a wildcard agrees with any text character. The host sends the pattern over and over, one entry per pair slot. It flags the final entry of each pass, and the period of the repetition sets the pattern length K, which may be anything from 1 to N.

The core is a linear array of N identical cells. Pattern entries enter at the left and move right. Text characters enter at the right and move left. Both streams advance one cell per clock, and valid items sit in alternate cells, so every text character meets every pattern entry exactly once. Each cell compares the pair it holds and keeps a running count along its own diagonal. When the closing pattern entry passes, the cell writes the finished count into the result slot that travels with the text character. The result therefore leaves the array together with the last character of its substring.

The block samples one pattern entry and one text character on every other clock. It marks those cycles on `in_take`. A count is presented on `cnt_out` with `cnt_vld` a fixed number of cycles after its text character was taken.

Top module: `spm_count_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cnt_vld` and `cnt_out` are 0 and `in_take` is 1.
- R2: `in_take` is high every other cycle, starting with the first cycle after reset. Values on `pat_chr`, `pat_last`, `pat_wild` and `txt_chr` in cycles where `in_take` is low have no effect on any count.
- R3: Each text character taken in cycle c yields exactly one `cnt_vld` pulse, in cycle c + 2*floor(N/2) + 2. Counts come out in text order, and `cnt_vld` is only ever high in `in_take` cycles.
- R4: The pattern is sent as entries p0..p(K-1) repeated, with `pat_last`=1 on entry K-1 only. For the text character at index b ≥ K-1, `cnt_out` equals the number of j in 0..K-1 where p_j is a wildcard or p_j equals text[b-K+1+j].
- R5: An entry taken with `pat_wild`=1 agrees with every text character, whatever its `pat_chr` value.
- R6: Any K from 1 to N is supported. `cnt_out` is clog2(N+1) bits wide and reaches N on a full match without wrapping. A cell restarts its count at 0 after each pair that carries the end flag.
- R7: Characters are compared on all CW bits. Two characters that differ only in the top bit disagree.
- R8: `cnt_out` is 0 in every cycle where `cnt_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_chr | input | CW | Pattern entry character |
| pat_last | input | 1 | Marks the final entry of one pattern pass |
| pat_wild | input | 1 | Marks the entry as a wildcard |
| txt_chr | input | CW | Text character |
| in_take | output | 1 | High in cycles where the inputs are sampled |
| cnt_out | output | clog2(N+1) | Agreement count for the substring ending at one text character |
| cnt_vld | output | 1 | Qualifies `cnt_out` |

## Verification
The assertions check the following on every cycle:
- the strict alternation of the sampling beat;
- that the running count of a cell moves by at most one per pair, rises by exactly one on a wildcard pair, and returns to zero after an end-flag pair;
- that no count ever exceeds N;
- that results only appear in sampling cycles.

Some behaviours only the bench scenarios can show: the exact count value for each window, the fixed latency and order of results, and that junk on the inputs between sampling cycles changes nothing. The bench sweeps every pattern length from 1 to N with random, repeating and constant text, all-wildcard patterns, and characters that differ only in their top bit.

// File: rtl/spm_pkg.sv
// Shared definitions for the systolic match counter.
// Assumes: all widths are derived from the cell count N and the character width.
package spm_pkg;

    // Two-beat cadence: inputs are sampled on LOAD, the following cycle is a gap.
    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_GAP  = 1'b1
    } beat_e;

    // Bits needed to hold any count from 0 to n inclusive.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Extra text register stages needed so that pattern and text meet in the
    // same cycle: one when the cell count is even, none when it is odd.
    function automatic int skew_stages(input int n);
        return ((n % 2) == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/spm_beat_gen.sv
// Beat generator: produces the alternating sampling strobe.
// Assumes: synchronous active-low reset; the first cycle after reset samples.
module spm_beat_gen (
    input  logic clk,
    input  logic rst_n,
    output logic take
);
    import spm_pkg::*;

    beat_e ph_q;

    // Toggle between the load and the gap beat every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_LOAD;
        end else begin
            ph_q <= (ph_q == PH_LOAD) ? PH_GAP : PH_LOAD;
        end
    end

    assign take = (ph_q == PH_LOAD);

    AST_BEAT_ALT_HI: assert property (@(posedge clk) disable iff (!rst_n) take |=> !take); // R2
    AST_BEAT_ALT_LO: assert property (@(posedge clk) disable iff (!rst_n) !take |=> take); // R2

endmodule

// File: rtl/spm_char_cmp.sv
// Bit-sliced character equality: one agreement bit per position, then an
// AND over all positions.
// Assumes: both operands are registered by the caller; purely combinational.
module spm_char_cmp #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    output logic          eq
);
    logic [CW-1:0] bit_eq;

    // One agreement slice per character bit.
    for (genvar g = 0; g < CW; g++) begin : g_slice
        assign bit_eq[g] = ~(a[g] ^ b[g]);
    end

    assign eq = &bit_eq;

endmodule

// File: rtl/spm_text_skew.sv
// Text entry skew: delays the text stream by STAGES cycles (0 or 1) so that
// counter-flowing items meet inside a cell rather than cross between cells.
// Assumes: STAGES is 0 or 1, chosen from the parity of the cell count.
module spm_text_skew #(
    parameter int CW     = 2,
    parameter int STAGES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] chr_i,
    input  logic          vld_i,
    output logic [CW-1:0] chr_o,
    output logic          vld_o
);
    if (STAGES == 1) begin : g_reg
        logic [CW-1:0] chr_q;
        logic          vld_q;

        // Hold the text item for one extra cycle before it enters the array.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chr_q <= '0;
                vld_q <= 1'b0;
            end else begin
                chr_q <= chr_i;
                vld_q <= vld_i;
            end
        end

        assign chr_o = chr_q;
        assign vld_o = vld_q;
    end else begin : g_pass
        assign chr_o = chr_i;
        assign vld_o = vld_i;
    end

endmodule

// File: rtl/spm_count_cell.sv
// One counting cell of the array. It holds one pattern stage (moving right),
// one text stage and its result slot (moving left), and a running agreement
// count for the diagonal of pairs that meet here.
// Assumes: the pattern and text valid bits coincide except while the streams
// are filling; a count grows only on pairs where both are valid.
module spm_count_cell #(
    parameter int N  = 8,
    parameter int CW = 2,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] p_chr_i,
    input  logic          p_last_i,
    input  logic          p_wild_i,
    input  logic          p_vld_i,
    input  logic [CW-1:0] s_chr_i,
    input  logic          s_vld_i,
    input  logic [RW-1:0] r_i,
    output logic [CW-1:0] p_chr_o,
    output logic          p_last_o,
    output logic          p_wild_o,
    output logic          p_vld_o,
    output logic [CW-1:0] s_chr_o,
    output logic          s_vld_o,
    output logic [RW-1:0] r_o
);
    logic [CW-1:0] p_chr_q;
    logic          p_last_q;
    logic          p_wild_q;
    logic          p_vld_q;
    logic [CW-1:0] s_chr_q;
    logic          s_vld_q;
    logic [RW-1:0] r_q;
    logic [RW-1:0] cnt_q;
    logic          eq;
    logic          hit;
    logic          pair_ok;

    spm_char_cmp #(.CW(CW)) u_cmp (
        .a  (p_chr_q),
        .b  (s_chr_q),
        .eq (eq)
    );

    assign hit     = p_wild_q | eq;
    assign pair_ok = p_vld_q & s_vld_q;

    // Advance both streams and the result slot by one cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_chr_q  <= '0;
            p_last_q <= 1'b0;
            p_wild_q <= 1'b0;
            p_vld_q  <= 1'b0;
            s_chr_q  <= '0;
            s_vld_q  <= 1'b0;
            r_q      <= '0;
        end else begin
            p_chr_q  <= p_chr_i;
            p_last_q <= p_last_i;
            p_wild_q <= p_wild_i;
            p_vld_q  <= p_vld_i;
            s_chr_q  <= s_chr_i;
            s_vld_q  <= s_vld_i;
            r_q      <= r_i;
        end
    end

    // Running count: restart after the closing entry, otherwise add agreements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (p_vld_q) begin
            if (p_last_q) begin
                cnt_q <= '0;
            end else if (s_vld_q && hit) begin
                cnt_q <= cnt_q + RW'(1);
            end
        end
    end

    // The closing pair overwrites the passing result slot with the finished count.
    always_comb begin
        if (pair_ok && p_last_q) begin
            r_o = cnt_q + RW'(hit);
        end else begin
            r_o = r_q;
        end
    end

    assign p_chr_o  = p_chr_q;
    assign p_last_o = p_last_q;
    assign p_wild_o = p_wild_q;
    assign p_vld_o  = p_vld_q;
    assign s_chr_o  = s_chr_q;
    assign s_vld_o  = s_vld_q;

    AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) int'(cnt_q) <= N); // R6
    AST_CNT_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
                         (p_vld_q && !p_last_q) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + RW'(1))); // R4
    AST_END_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n)
                         (p_vld_q && p_last_q) |=> (cnt_q == '0)); // R6
    AST_WILD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
                         (pair_ok && p_wild_q && !p_last_q) |=> (cnt_q == $past(cnt_q) + RW'(1))); // R5

endmodule

// File: rtl/spm_count_top.sv
// Systolic match counter top. It chains N counting cells: the pattern enters
// cell 0 and travels right, the text enters cell N-1 (through the parity skew)
// and travels left with its result slot, and cell 0 feeds the output register.
// Assumes: the host recirculates a pattern of length 1..N with the end flag on
// its final entry, and presents one pair on each cycle where in_take is high.
module spm_count_top #(
    parameter int N  = 8,
    parameter int CW = 2,
    localparam int RW = spm_pkg::cnt_width(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pat_chr,
    input  logic          pat_last,
    input  logic          pat_wild,
    input  logic [CW-1:0] txt_chr,
    output logic          in_take,
    output logic [RW-1:0] cnt_out,
    output logic          cnt_vld
);
    localparam int SKEW = spm_pkg::skew_stages(N);

    logic [CW-1:0] pc [0:N];
    logic          pl [0:N];
    logic          pw [0:N];
    logic          pv [0:N];
    logic [CW-1:0] sc [0:N];
    logic          sv [0:N];
    logic [RW-1:0] rr [0:N];
    logic          take;

    spm_beat_gen u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take)
    );

    assign in_take = take;

    // The pattern enters on the left edge; gap cycles enter as bubbles.
    assign pc[0] = pat_chr;
    assign pl[0] = pat_last;
    assign pw[0] = pat_wild;
    assign pv[0] = take;

    spm_text_skew #(.CW(CW), .STAGES(SKEW)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .chr_i (txt_chr),
        .vld_i (take),
        .chr_o (sc[N]),
        .vld_o (sv[N])
    );

    // Empty result slots enter on the right edge.
    assign rr[N] = '0;

    for (genvar i = 0; i < N; i++) begin : g_cell
        spm_count_cell #(.N(N), .CW(CW), .RW(RW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .p_chr_i  (pc[i]),
            .p_last_i (pl[i]),
            .p_wild_i (pw[i]),
            .p_vld_i  (pv[i]),
            .s_chr_i  (sc[i+1]),
            .s_vld_i  (sv[i+1]),
            .r_i      (rr[i+1]),
            .p_chr_o  (pc[i+1]),
            .p_last_o (pl[i+1]),
            .p_wild_o (pw[i+1]),
            .p_vld_o  (pv[i+1]),
            .s_chr_o  (sc[i]),
            .s_vld_o  (sv[i]),
            .r_o      (rr[i])
        );
    end

    // Register the result leaving cell 0, zeroed on empty slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_vld <= 1'b0;
            cnt_out <= '0;
        end else begin
            cnt_vld <= sv[0];
            cnt_out <= sv[0] ? rr[0] : '0;
        end
    end

    AST_VLD_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n) cnt_vld |-> in_take); // R3
    AST_OUT_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) cnt_vld |-> (int'(cnt_out) <= N)); // R6

endmodule

// File: tb/sim_spm_count_top.sv
// Bench for the systolic match counter: sweeps every pattern length with
// several text kinds and checks each count against a sliding-window sum.
module sim_spm_count_top;
    localparam int N   = 8;
    localparam int CW  = 2;
    localparam int RW  = $clog2(N + 1);
    localparam int LAT = 2 * (N / 2) + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] pat_chr = '0;
    logic          pat_last = 1'b0;
    logic          pat_wild = 1'b0;
    logic [CW-1:0] txt_chr = '0;
    logic          in_take;
    logic [RW-1:0] cnt_out;
    logic          cnt_vld;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    int pat [0:15];
    bit wild [0:15];
    int txt [0:511];
    int take_cyc [0:511];
    int cval = 0;

    spm_count_top #(.N(N), .CW(CW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pat_chr  (pat_chr),
        .pat_last (pat_last),
        .pat_wild (pat_wild),
        .txt_chr  (txt_chr),
        .in_take  (in_take),
        .cnt_out  (cnt_out),
        .cnt_vld  (cnt_vld)
    );

    always #10 clk = ~clk;

    function automatic int rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed >> 8);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs one scenario; the pattern is in pat/wild, tmode picks the text kind.
    task automatic run_case(input string tag, input int k, input int tmode, input int npairs);
        int n = 0;
        int m = 0;
        int cyc = 0;
        int guard = 0;
        int limit = 2 * npairs + LAT + 20;
        do_reset();
        while (m < npairs && guard < limit) begin
            if (cnt_vld) begin
                if (m >= k - 1) begin
                    int exp = 0;
                    for (int j = 0; j < k; j++) begin
                        if (wild[j] || pat[j] == txt[m - k + 1 + j]) exp++;
                    end
                    chk(tag, int'(cnt_out), exp);
                end
                chk("R3 latency", cyc - take_cyc[m], LAT);
                m++;
            end else begin
                chk("R8 idle output", int'(cnt_out), 0);
            end
            chk("R2 beat", int'(in_take), (cyc % 2 == 0) ? 1 : 0);
            if (in_take) begin
                int idx = n % k;
                pat_chr  = wild[idx] ? CW'(rnd()) : CW'(pat[idx]);
                pat_wild = wild[idx];
                pat_last = (idx == k - 1);
                if (tmode == 0)      txt[n] = rnd() % (1 << CW);
                else if (tmode == 1) txt[n] = pat[idx];
                else                 txt[n] = cval;
                txt_chr = CW'(txt[n]);
                take_cyc[n] = cyc;
                n++;
            end else begin
                // Gap cycle: junk everywhere, which must not matter (R2).
                pat_chr  = CW'(rnd());
                pat_wild = rnd() % 2 == 1;
                pat_last = rnd() % 2 == 1;
                txt_chr  = CW'(rnd());
            end
            cyc++;
            guard++;
            @(negedge clk);
        end
        if (m < npairs) chk({tag, " result count"}, m, npairs);
    endtask

    initial begin
        // R1: reset state, observed in the first cycle after release.
        do_reset();
        chk("R1 vld", int'(cnt_vld), 0);
        chk("R1 cnt", int'(cnt_out), 0);
        chk("R1 take", int'(in_take), 1);

        // R4: every length with random pattern, sparse wildcards, random text.
        for (int k = 1; k <= N; k++) begin
            for (int j = 0; j < k; j++) begin
                pat[j]  = rnd() % (1 << CW);
                wild[j] = (rnd() % 4) == 0;
            end
            run_case("R4 random", k, 0, 40);
        end

        // R6: every length with text repeating the pattern; full matches reach k.
        for (int k = 1; k <= N; k++) begin
            for (int j = 0; j < k; j++) begin
                pat[j]  = rnd() % (1 << CW);
                wild[j] = 1'b0;
            end
            run_case("R6 periodic", k, 1, 3 * k + 8);
        end

        // R5: all-wildcard patterns count every position.
        for (int j = 0; j < N; j++) begin pat[j] = 0; wild[j] = 1'b1; end
        run_case("R5 all wild", N, 0, 30);
        run_case("R5 all wild short", 3, 0, 30);

        // R7: characters differing only in the top bit must disagree.
        for (int j = 0; j < 4; j++) begin pat[j] = 2; wild[j] = 1'b0; end
        cval = 0;
        run_case("R7 top bit", 4, 2, 20);
        for (int j = 0; j < 4; j++) pat[j] = 1;
        cval = 3;
        run_case("R7 top bit set", 4, 2, 20);
        for (int j = 0; j < 4; j++) pat[j] = 3;
        run_case("R7 equal", 4, 2, 20);

        // R6: maximum length, constant text equal to pattern, count N.
        for (int j = 0; j < N; j++) begin pat[j] = 1; wild[j] = 1'b0; end
        cval = 1;
        run_case("R6 full length", N, 2, 30);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule